// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a DSP-style datapath. A signed or unsigned multiplier, 17 bits on each side, feeds a 41-bit adder/subtracter. The adder writes one of two 40-bit accumulators. Each operation is a single cycle. The operation code, the target select, the two 16-bit operands and the mode bits are sampled together on a rising clock edge while `op_valid` is high. The selected accumulator updates on that same edge.

Multiply operations are plain multiply, negated multiply, multiply-accumulate and multiply-subtract. Squared-difference operations load or add (x − y)². Three operations combine the two accumulators without using the operands. There is also a clear, and a no-change code. Every write passes through optional saturation, which can clamp to the 1.31 range or to the full 40-bit range. Each accumulator keeps its own overflow and clamp flags.

A rounded 16-bit readout of either accumulator is always available. It is taken from bits 31:16 and can round either conventionally or to even.

Top module: `mac_dual_acc`

## Requirements
- R1: After reset both accumulators are zero, all flags are zero, and `rnd_out` is zero.
- R2: Multiply codes: 5 loads x·y, 6 loads −x·y, 3 adds x·y, and 4 subtracts x·y. With `uns_mode`=0 the operands are two's complement. With `uns_mode`=1 they are unsigned.
- R3: With `frac_mode`=1 the product is doubled. In signed fractional mode, 0x8000·0x8000 on a multiply code gives 0x007FFFFFFF.
- R4: Code 1 loads (x−y)². Code 2 adds (x−y)². The difference is formed in 17 bits under the same sign mode, and fractional mode doubles the square.
- R5: Code 0 clears the target. Code 7 changes nothing. Codes 11 to 15, and any cycle with `op_valid`=0, change no output.
- R6: Code 8 sets the target to target + other. Code 9 sets it to target − other. Code 10 sets it to −target. Operands are ignored by all three.
- R7: `acc_sel`=0 writes `acc_a` and `acc_sel`=1 writes `acc_b`. The other accumulator and its flags hold.
- R8: With the target's saturation enable set and `super_sat`=0, a result outside [−2³¹, 2³¹−1] is clamped to the nearer bound.
- R9: With saturation enabled and `super_sat`=1, only a result outside the 40-bit signed range is clamped. It goes to 0x7FFFFFFFFF or 0x8000000000.
- R10: With saturation disabled, the result wraps modulo 2⁴⁰.
- R11: On each write, flag bit [i] of accumulator i is set as follows. `ovf_hi` reports that the exact result left the 40-bit range. `ovf_lo` reports that it left the 1.31 range. `sat_hit` reports that a clamp was applied.
- R12: `rnd_out` rounds accumulator `rd_sel` at bit 15. With `conv_rnd`=0 it rounds half up. With `conv_rnd`=1 an exact half rounds to even bit 16. The result of bits 39:16 plus the increment then saturates to 16-bit signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Apply the operation on this edge |
| op | input | 4 | Operation code |
| acc_sel | input | 1 | Target accumulator (0 = A, 1 = B) |
| x_in | input | 16 | Operand x |
| y_in | input | 16 | Operand y |
| frac_mode | input | 1 | Fractional multiply (product doubled) |
| uns_mode | input | 1 | Unsigned operands |
| conv_rnd | input | 1 | Convergent rounding for the readout |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| super_sat | input | 1 | Clamp at 40 bits instead of 32 |
| rd_sel | input | 1 | Accumulator shown on rnd_out |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| rnd_out | output | 16 | Rounded, saturated readout |
| ovf_hi | output | 2 | 40-bit overflow flags, [0]=A, [1]=B |
| ovf_lo | output | 2 | 1.31 range flags |
| sat_hit | output | 2 | Clamp-applied flags |

## Verification
The hold assertions assume the caller treats codes 11 to 15 as no-ops. The normal-saturation check assumes the enable and mode bits are steady for the edge they are sampled on. The bench drives every input on the falling edge and keeps it steady through the next rising edge, so each operation sees one clean set of inputs. Each result is compared against a 64-bit integer model shortly after the edge that produced it. The readout inputs are held until that comparison, so the rounded value belongs to the same operation.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int DATA_W = 16;
    localparam int ACC_W  = 40;

    typedef enum logic [3:0] {
        OP_CLR    = 4'd0,
        OP_SQ     = 4'd1,
        OP_SQACC  = 4'd2,
        OP_MAC    = 4'd3,
        OP_MSC    = 4'd4,
        OP_MUL    = 4'd5,
        OP_MULN   = 4'd6,
        OP_HOLD   = 4'd7,
        OP_ADDACC = 4'd8,
        OP_SUBACC = 4'd9,
        OP_NEGACC = 4'd10
    } mac_op_e;
endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          uns,
    input  logic          frac,
    input  logic          sq,
    output logic [AW-1:0] prod
);
    localparam int MW = DW + 1;
    localparam int PW = 2 * MW;
    localparam logic [DW-1:0] MIN_OPND = {1'b1, {(DW-1){1'b0}}};
    localparam logic [AW-1:0] FRAC_MAX = {{(AW-2*DW+1){1'b0}}, {(2*DW-1){1'b1}}};

    logic signed [MW-1:0] xe, ye, ma, mb;
    logic signed [PW-1:0] pw;
    logic [AW-1:0]        pe;
    logic                 clamp;

    always_comb begin
        xe    = uns ? {1'b0, x} : {x[DW-1], x};
        ye    = uns ? {1'b0, y} : {y[DW-1], y};
        ma    = sq ? (xe - ye) : xe;
        mb    = sq ? ma : ye;
        pw    = $signed({{MW{ma[MW-1]}}, ma}) * $signed({{MW{mb[MW-1]}}, mb});
        pe    = {{(AW-PW){pw[PW-1]}}, pw};
        clamp = frac && !uns && !sq && (x == MIN_OPND) && (y == MIN_OPND);
        if (clamp)
            prod = FRAC_MAX;
        else if (frac)
            prod = pe << 1;
        else
            prod = pe;
    end
endmodule

// File: rtl/mac_addsat.sv
module mac_addsat #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          neg_b,
    input  logic          sat_en,
    input  logic          super_sat,
    output logic [AW-1:0] res,
    output logic          ov_hi,
    output logic          ov_lo,
    output logic          clamped
);
    localparam int FW = 2 * DW - 1;
    localparam logic [AW-1:0] NMAX = {{(AW-FW){1'b0}}, {FW{1'b1}}};
    localparam logic [AW-1:0] NMIN = {{(AW-FW){1'b1}}, {FW{1'b0}}};
    localparam logic [AW-1:0] SMAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] SMIN = {1'b1, {(AW-1){1'b0}}};

    logic [AW:0] ae, be, raw;

    always_comb begin
        ae      = {a[AW-1], a};
        be      = {b[AW-1], b};
        raw     = neg_b ? (ae - be) : (ae + be);
        ov_hi   = raw[AW] ^ raw[AW-1];
        ov_lo   = !((&raw[AW:FW]) || !(|raw[AW:FW]));
        clamped = sat_en && (super_sat ? ov_hi : ov_lo);
        if (clamped)
            res = raw[AW] ? (super_sat ? SMIN : NMIN) : (super_sat ? SMAX : NMAX);
        else
            res = raw[AW-1:0];
    end
endmodule

// File: rtl/mac_round.sv
module mac_round #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [AW-1:0] acc,
    input  logic          conv,
    output logic [DW-1:0] rnd
);
    localparam int HW = AW - DW;
    localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] RMAX = {1'b0, {(DW-1){1'b1}}};

    logic [DW-1:0] low;
    logic          up;
    logic [HW:0]   sum;
    logic          in_rng;

    always_comb begin
        low    = acc[DW-1:0];
        up     = conv ? ((low > HALF) || ((low == HALF) && acc[DW])) : low[DW-1];
        sum    = {acc[AW-1], acc[AW-1:DW]} + {{HW{1'b0}}, up};
        in_rng = (&sum[HW:DW-1]) || !(|sum[HW:DW-1]);
        rnd    = in_rng ? sum[DW-1:0] : (sum[HW] ? HALF : RMAX);
    end
endmodule

// File: rtl/mac_dual_acc.sv
module mac_dual_acc
    import mac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ACC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op,
    input  logic          acc_sel,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic          frac_mode,
    input  logic          uns_mode,
    input  logic          conv_rnd,
    input  logic          sat_en_a,
    input  logic          sat_en_b,
    input  logic          super_sat,
    input  logic          rd_sel,
    output logic [AW-1:0] acc_a,
    output logic [AW-1:0] acc_b,
    output logic [DW-1:0] rnd_out,
    output logic [1:0]    ovf_hi,
    output logic [1:0]    ovf_lo,
    output logic [1:0]    sat_hit
);
    typedef struct packed {
        logic [AW-1:0] acc_a;
        logic [AW-1:0] acc_b;
        logic [1:0]    ov_hi;
        logic [1:0]    ov_lo;
        logic [1:0]    sat;
    } state_t;

    state_t        st_d, st_q;
    logic [AW-1:0] prod, cur, oth, opa, opb, res;
    logic          negb, wr, sq, hi, lo, clp;
    logic [AW-1:0] acc_v [2];
    logic [DW-1:0] rnd_v [2];

    assign sq = (op == OP_SQ) || (op == OP_SQACC);

    mac_mul #(.DW(DW), .AW(AW)) u_mul (
        .x(x_in), .y(y_in), .uns(uns_mode), .frac(frac_mode), .sq(sq), .prod(prod)
    );

    mac_addsat #(.DW(DW), .AW(AW)) u_add (
        .a(opa), .b(opb), .neg_b(negb),
        .sat_en(acc_sel ? sat_en_b : sat_en_a), .super_sat(super_sat),
        .res(res), .ov_hi(hi), .ov_lo(lo), .clamped(clp)
    );

    always_comb begin
        cur  = acc_sel ? st_q.acc_b : st_q.acc_a;
        oth  = acc_sel ? st_q.acc_a : st_q.acc_b;
        opa  = '0;
        opb  = '0;
        negb = 1'b0;
        wr   = 1'b0;
        if (op_valid) begin
            case (op)
                OP_CLR:    wr = 1'b1;
                OP_SQ:     begin opb = prod; wr = 1'b1; end
                OP_SQACC:  begin opa = cur; opb = prod; wr = 1'b1; end
                OP_MAC:    begin opa = cur; opb = prod; wr = 1'b1; end
                OP_MSC:    begin opa = cur; opb = prod; negb = 1'b1; wr = 1'b1; end
                OP_MUL:    begin opb = prod; wr = 1'b1; end
                OP_MULN:   begin opb = prod; negb = 1'b1; wr = 1'b1; end
                OP_ADDACC: begin opa = cur; opb = oth; wr = 1'b1; end
                OP_SUBACC: begin opa = cur; opb = oth; negb = 1'b1; wr = 1'b1; end
                OP_NEGACC: begin opb = cur; negb = 1'b1; wr = 1'b1; end
                default:   wr = 1'b0;
            endcase
        end
        st_d = st_q;
        if (wr) begin
            if (acc_sel) st_d.acc_b = res;
            else         st_d.acc_a = res;
            st_d.ov_hi[acc_sel] = hi;
            st_d.ov_lo[acc_sel] = lo;
            st_d.sat[acc_sel]   = clp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_v[0] = st_q.acc_a;
    assign acc_v[1] = st_q.acc_b;

    for (genvar g = 0; g < 2; g++) begin : g_rnd
        mac_round #(.DW(DW), .AW(AW)) u_rnd (
            .acc(acc_v[g]), .conv(conv_rnd), .rnd(rnd_v[g])
        );
    end

    assign rnd_out = rnd_v[rd_sel];
    assign acc_a   = st_q.acc_a;
    assign acc_b   = st_q.acc_b;
    assign ovf_hi  = st_q.ov_hi;
    assign ovf_lo  = st_q.ov_lo;
    assign sat_hit = st_q.sat;
endmodule

// File: rtl/mac_dual_acc_chk.sv
module mac_dual_acc_chk
    import mac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ACC_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op,
    input logic          acc_sel,
    input logic          sat_en_a,
    input logic          super_sat,
    input logic [AW-1:0] acc_a,
    input logic [AW-1:0] acc_b,
    input logic [1:0]    ovf_hi,
    input logic [1:0]    ovf_lo,
    input logic [1:0]    sat_hit
);
    localparam int FW = 2 * DW - 1;
    logic writes;
    assign writes = op_valid && (op != OP_HOLD) && (op <= OP_NEGACC);

    // R5
    hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_HOLD) |=> ($stable(acc_a) && $stable(acc_b)));

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_a) && $stable(acc_b) && $stable(sat_hit) && $stable(ovf_hi)));

    // R5
    clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_CLR && !acc_sel) |=> (acc_a == '0 && !ovf_lo[0] && !sat_hit[0]));

    // R7
    other_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel) |=> ($stable(acc_b) && $stable(sat_hit[1]) && $stable(ovf_lo[1])));

    // R7
    other_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && acc_sel) |=> ($stable(acc_a) && $stable(sat_hit[0]) && $stable(ovf_lo[0])));

    // R8
    norm_sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (writes && !acc_sel && sat_en_a && !super_sat) |=> ((&acc_a[AW-1:FW]) || !(|acc_a[AW-1:FW])));

    // R11
    clamp_needs_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sat_hit & ~ovf_lo) == 2'b00));

    // R11
    hi_implies_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_hi & ~ovf_lo) == 2'b00));
endmodule

bind mac_dual_acc mac_dual_acc_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .acc_sel(acc_sel),
    .sat_en_a(sat_en_a), .super_sat(super_sat), .acc_a(acc_a), .acc_b(acc_b),
    .ovf_hi(ovf_hi), .ovf_lo(ovf_lo), .sat_hit(sat_hit)
);

// File: tb/tb_mac_dual_acc.sv
`timescale 1ns/1ps
module tb_mac_dual_acc;
    logic        clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, acc_sel = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [15:0] x_in = '0, y_in = '0;
    logic        frac_mode = 0, uns_mode = 0, conv_rnd = 0;
    logic        sat_en_a = 0, sat_en_b = 0, super_sat = 0, rd_sel = 0;
    logic [39:0] acc_a, acc_b;
    logic [15:0] rnd_out;
    logic [1:0]  ovf_hi, ovf_lo, sat_hit;

    mac_dual_acc dut (.*);

    always #4 clk = ~clk;

    typedef struct {
        logic [39:0] a, b;
        logic [1:0]  hi, lo, st;
        logic [15:0] r;
        string       tag;
    } exp_t;
    exp_t q[$];

    int checks = 0, fails = 0;
    bit g_frac = 0, g_uns = 0, g_conv = 0, g_sa = 0, g_sb = 0, g_sup = 0, g_rd = 0;
    longint ma [2];
    logic [1:0] mhi = 0, mlo = 0, mst = 0;
    localparam longint P39 = 64'sh80_0000_0000;
    localparam longint P31 = 64'sh8000_0000;

    function automatic longint mul_ref(logic [15:0] x, logic [15:0] y, bit sq);
        longint a, b, p;
        a = g_uns ? longint'(x) : longint'($signed(x));
        b = g_uns ? longint'(y) : longint'($signed(y));
        if (sq) begin a = a - b; b = a; end
        p = a * b;
        if (g_frac) begin
            if (!g_uns && !sq && x == 16'h8000 && y == 16'h8000) p = 64'sh7FFF_FFFF;
            else p = p * 2;
        end
        return p;
    endfunction

    function automatic logic [15:0] rnd_ref(longint v, bit cv);
        longint h, low, r;
        bit up;
        low = v & 64'hFFFF;
        h   = v >>> 16;
        up  = cv ? ((low > 32768) || (low == 32768 && h[0])) : (low >= 32768);
        r   = h + longint'(up);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r[15:0];
    endfunction

    task automatic do_op(input logic [3:0] o, input bit s, input logic [15:0] x,
                         input logic [15:0] y, input string tag, input bit v = 1);
        longint cur, oth, raw, val;
        bit wr, h, l, c, en;
        exp_t e;
        @(negedge clk);
        op = o; acc_sel = s; x_in = x; y_in = y; op_valid = v;
        frac_mode = g_frac; uns_mode = g_uns; conv_rnd = g_conv;
        sat_en_a = g_sa; sat_en_b = g_sb; super_sat = g_sup; rd_sel = g_rd;
        cur = ma[s]; oth = ma[!s]; wr = v; raw = 0;
        case (o)
            4'd0:  raw = 0;
            4'd1:  raw = mul_ref(x, y, 1);
            4'd2:  raw = cur + mul_ref(x, y, 1);
            4'd3:  raw = cur + mul_ref(x, y, 0);
            4'd4:  raw = cur - mul_ref(x, y, 0);
            4'd5:  raw = mul_ref(x, y, 0);
            4'd6:  raw = -mul_ref(x, y, 0);
            4'd8:  raw = cur + oth;
            4'd9:  raw = cur - oth;
            4'd10: raw = -cur;
            default: wr = 0;
        endcase
        if (wr) begin
            h  = (raw < -P39) || (raw > P39 - 1);
            l  = (raw < -P31) || (raw > P31 - 1);
            en = s ? g_sb : g_sa;
            c  = en && (g_sup ? h : l);
            if (c) val = (raw < 0) ? (g_sup ? -P39 : -P31) : (g_sup ? P39 - 1 : P31 - 1);
            else begin
                val = raw & (P39 * 2 - 1);
                if (val >= P39) val = val - P39 * 2;
            end
            ma[s] = val; mhi[s] = h; mlo[s] = l; mst[s] = c;
        end
        e.a = ma[0][39:0]; e.b = ma[1][39:0];
        e.hi = mhi; e.lo = mlo; e.st = mst;
        e.r = rnd_ref(ma[g_rd], g_conv); e.tag = tag;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (acc_a !== e.a || acc_b !== e.b || ovf_hi !== e.hi || ovf_lo !== e.lo ||
                    sat_hit !== e.st || rnd_out !== e.r) begin
                    fails++;
                    $display("FAIL %s: got a=%h b=%h hi=%b lo=%b sat=%b rnd=%h, expected a=%h b=%h hi=%b lo=%b sat=%b rnd=%h",
                             e.tag, acc_a, acc_b, ovf_hi, ovf_lo, sat_hit, rnd_out,
                             e.a, e.b, e.hi, e.lo, e.st, e.r);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: run still active, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : stimulus
        ma[0] = 0; ma[1] = 0;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        // R1 reset state
        if (acc_a !== 0 || acc_b !== 0 || ovf_hi !== 0 || ovf_lo !== 0 || sat_hit !== 0 || rnd_out !== 0) begin
            fails++;
            $display("FAIL R1: got a=%h b=%h flags=%b%b%b rnd=%h, expected all zero",
                     acc_a, acc_b, ovf_hi, ovf_lo, sat_hit, rnd_out);
        end
        rst_n = 1'b1;

        // R2 integer multiplies, both sign modes
        do_op(4'd5, 0, 16'd3, 16'hFFFB, "R2");
        do_op(4'd3, 0, 16'd100, 16'd200, "R2");
        do_op(4'd4, 0, 16'd7, 16'd9, "R2");
        do_op(4'd6, 1, 16'd12, 16'd13, "R2");
        do_op(4'd5, 1, 16'h7FFF, 16'h8000, "R2");
        g_uns = 1;
        do_op(4'd5, 0, 16'hFFFF, 16'hFFFF, "R2");
        do_op(4'd3, 0, 16'hFFFF, 16'hFFFF, "R2");
        g_uns = 0;
        do_op(4'd5, 1, 16'hFFFF, 16'hFFFF, "R2");

        // R3 fractional mode and corner clamp
        g_frac = 1;
        do_op(4'd5, 0, 16'h8000, 16'h8000, "R3");
        do_op(4'd5, 1, 16'h8000, 16'h7FFF, "R3");
        do_op(4'd3, 0, 16'h4000, 16'h4000, "R3");
        g_uns = 1;
        do_op(4'd5, 1, 16'h8000, 16'h8000, "R3");
        g_uns = 0; g_frac = 0;

        // R4 squared difference
        do_op(4'd1, 0, 16'd10, 16'd3, "R4");
        do_op(4'd2, 0, 16'h8000, 16'h7FFF, "R4");
        g_uns = 1;
        do_op(4'd1, 1, 16'h0000, 16'hFFFF, "R4");
        g_uns = 0; g_frac = 1;
        do_op(4'd2, 1, 16'h1000, 16'hF000, "R4");
        g_frac = 0;

        // R5 clear, hold code, reserved codes, idle cycle
        do_op(4'd0, 0, 16'h1234, 16'h5678, "R5");
        do_op(4'd7, 1, 16'h1234, 16'h5678, "R5");
        do_op(4'd11, 1, 16'h1234, 16'h5678, "R5");
        do_op(4'd15, 0, 16'h1234, 16'h5678, "R5");
        do_op(4'd3, 1, 16'h7FFF, 16'h7FFF, "R5", 0);

        // R6 accumulator-to-accumulator, R7 target select
        do_op(4'd5, 0, 16'd1000, 16'd1000, "R7");
        do_op(4'd8, 1, 16'hFFFF, 16'hFFFF, "R6");
        do_op(4'd9, 0, 16'h0001, 16'h0002, "R6");
        do_op(4'd10, 1, 16'h0000, 16'h0000, "R6");
        do_op(4'd9, 1, 16'h0000, 16'h0000, "R6");

        // R8 normal saturation, positive and negative
        g_frac = 1; g_sa = 1; g_sb = 1; g_sup = 0;
        do_op(4'd5, 0, 16'h7FFF, 16'h7FFF, "R8");
        do_op(4'd3, 0, 16'h7FFF, 16'h7FFF, "R8");
        do_op(4'd3, 0, 16'h7FFF, 16'h7FFF, "R8");
        do_op(4'd5, 1, 16'h8000, 16'h7FFF, "R8");
        do_op(4'd3, 1, 16'h8000, 16'h7FFF, "R8");
        do_op(4'd10, 1, 16'h0000, 16'h0000, "R8");

        // R9 super saturation while values grow past 40 bits
        g_sup = 1;
        for (int i = 0; i < 12; i++) begin
            do_op(4'd8, 0, 16'h0, 16'h0, "R9");
            do_op(4'd8, 1, 16'h0, 16'h0, "R9");
        end
        do_op(4'd10, 0, 16'h0, 16'h0, "R9");
        do_op(4'd9, 0, 16'h0, 16'h0, "R9");

        // R10 wrap without saturation, R11 flags throughout
        g_sa = 0; g_sb = 0;
        for (int i = 0; i < 4; i++) begin
            do_op(4'd8, 0, 16'h0, 16'h0, "R10");
            do_op(4'd8, 1, 16'h0, 16'h0, "R11");
        end
        g_rd = 1;
        do_op(4'd9, 1, 16'h0, 16'h0, "R11");

        // R12 rounding: ties, even/odd, above half, readout saturation
        g_frac = 0; g_uns = 1; g_rd = 0; g_conv = 0;
        do_op(4'd5, 0, 16'd1, 16'h8000, "R12");
        g_conv = 1;
        do_op(4'd7, 0, 16'd0, 16'd0, "R12");
        do_op(4'd5, 0, 16'd3, 16'h8000, "R12");
        g_conv = 0;
        do_op(4'd7, 0, 16'd0, 16'd0, "R12");
        g_conv = 1;
        do_op(4'd5, 0, 16'd1, 16'h8001, "R12");
        do_op(4'd5, 0, 16'd2, 16'h7FFF, "R12");
        g_uns = 0; g_frac = 1;
        do_op(4'd5, 0, 16'h7FFF, 16'h7FFF, "R12");
        do_op(4'd8, 0, 16'h0, 16'h0, "R12");
        g_rd = 1;
        do_op(4'd10, 1, 16'h0, 16'h0, "R12");

        repeat (3) @(posedge clk);
        #5;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule